// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block is the synchronous state machine that selects the operating mode of a LIN bus transceiver. It uses the enable input and the transmit-data input from the host, a supply-undervoltage flag, a bus wake-up detect, and edge-detected local-wake and ignition pulses. All of these arrive already synchronized to the block clock. From them the block sets the enables for the voltage regulator, the transmit path and the receive path.

A falling enable puts the block in one of two low-power modes. The level of the transmit-data input at that moment picks which one. Any wake-up event returns the block to the fail-safe mode. The block stores the source of that wake-up. A local source (the wake pin or the ignition input) makes the block request that the transmit-data pin be pulled low. The host reads that low level to learn that a local wake-up happened. A rising enable then moves the block to normal operation.

Top module: `lin_mode_top`

## Requirements
- R1: After synchronous reset the mode is 2'b00 (fail-safe), the regulator enable is 1, the transmit and receive enables are 0, the drive-low request is 0 and the wake source is 2'b00 (none). All outputs are registered.
- R2: In fail-safe, a rising enable (high now, low in the previous cycle) moves the block to mode 2'b01 (normal) at the next edge. Normal has both path enables at 1, and the wake source becomes 2'b00.
- R3: In normal, enable low with transmit-data high moves the block to mode 2'b10 (silent). Silent has the regulator enable at 1 and both path enables at 0.
- R4: In normal, enable low with transmit-data low moves the block to mode 2'b11 (sleep). Sleep has the regulator enable at 0 and both path enables at 0.
- R5: In silent or sleep, any wake pulse moves the block to fail-safe at the next edge and records its source: 2'b01 bus, 2'b10 wake pin, 2'b11 ignition. When several pulses arrive together, the wake pin wins over ignition, and ignition wins over the bus.
- R6: The drive-low request is 1 exactly when the mode is fail-safe and the recorded source is the wake pin or ignition.
- R7: The transmit enable is 0 in any cycle that follows a cycle with the undervoltage flag high. The receive enable does not depend on the flag.
- R8: Wake pulses in normal or fail-safe mode change neither the mode nor the recorded source.
- R9: In silent or sleep with no wake pulse, the mode stays the same, even when the enable rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| enIn | input | 1 | Enable from host |
| txdIn | input | 1 | Transmit data level from host |
| uvFlag | input | 1 | Supply undervoltage flag |
| busWake | input | 1 | Bus wake-up detect pulse |
| pinWake | input | 1 | Local wake pin pulse |
| ignWake | input | 1 | Ignition edge pulse |
| modeOut | output | 2 | Current mode (00 fail-safe, 01 normal, 10 silent, 11 sleep) |
| regEn | output | 1 | Regulator enable |
| txEn | output | 1 | Transmit path enable |
| rxEn | output | 1 | Receive path enable |
| txdDriveLow | output | 1 | Request to pull the transmit-data pin low |
| wakeSrc | output | 2 | Recorded wake-up source |

## Verification
Several properties are checked on every cycle by assertions:
- the transitions out of normal and out of the low-power modes;
- the holding of sleep mode while no wake pulse arrives;
- the regulator being off in sleep;
- the drive-low request appearing only in fail-safe;
- the wake source being cleared in normal;
- undervoltage blocking transmission.

Some behaviours can only be shown by the bench scenarios, which compare every output against a behavioural model on every clock:
- the priority between wake sources that arrive together;
- wake pulses being ignored in normal and fail-safe;
- a rising enable being needed to leave fail-safe;
- the recorded source surviving until the next entry to normal.

// File: rtl/linmode_pkg.sv
package linmode_pkg;
  typedef enum logic [1:0] {
    MODE_FAILSAFE = 2'b00,
    MODE_NORMAL   = 2'b01,
    MODE_SILENT   = 2'b10,
    MODE_SLEEP    = 2'b11
  } lin_mode_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_BUS  = 2'b01,
    SRC_PIN  = 2'b10,
    SRC_IGN  = 2'b11
  } wake_src_e;

  typedef struct packed {
    lin_mode_e nextMode;
    logic      loadSrc;
    logic      clearSrc;
    wake_src_e newSrc;
  } ctrl_strobe_t;
endpackage

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
  import linmode_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         enIn,
  input  logic         txdIn,
  input  logic         busWake,
  input  logic         pinWake,
  input  logic         ignWake,
  output ctrl_strobe_t strobe,
  output lin_mode_e    curMode
);
  lin_mode_e modeQ;
  logic      enPrev;
  logic      anyWake;
  logic      enRise;
  wake_src_e pickSrc;

  assign anyWake = busWake | pinWake | ignWake;
  assign enRise  = enIn & ~enPrev;

  // local pin first, then ignition, then bus
  always_comb begin
    if (pinWake)      pickSrc = SRC_PIN;
    else if (ignWake) pickSrc = SRC_IGN;
    else if (busWake) pickSrc = SRC_BUS;
    else              pickSrc = SRC_NONE;
  end

  always_comb begin
    strobe.nextMode = modeQ;
    strobe.loadSrc  = 1'b0;
    strobe.clearSrc = 1'b0;
    strobe.newSrc   = pickSrc;
    unique case (modeQ)
      MODE_FAILSAFE: begin
        if (enRise) begin
          strobe.nextMode = MODE_NORMAL;
          strobe.clearSrc = 1'b1;
        end
      end
      MODE_NORMAL: begin
        if (!enIn) strobe.nextMode = txdIn ? MODE_SILENT : MODE_SLEEP;
      end
      MODE_SILENT, MODE_SLEEP: begin
        if (anyWake) begin
          strobe.nextMode = MODE_FAILSAFE;
          strobe.loadSrc  = 1'b1;
        end
      end
      default: strobe.nextMode = MODE_FAILSAFE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ  <= MODE_FAILSAFE;
      enPrev <= 1'b0;
    end else begin
      modeQ  <= strobe.nextMode;
      enPrev <= enIn;
    end
  end

  assign curMode = modeQ;

  a_r3_silent_entry: assert property (@(posedge clk) disable iff (rst)
    (modeQ == MODE_NORMAL && !enIn && txdIn) |=> (modeQ == MODE_SILENT));

  a_r4_sleep_entry: assert property (@(posedge clk) disable iff (rst)
    (modeQ == MODE_NORMAL && !enIn && !txdIn) |=> (modeQ == MODE_SLEEP));

  a_r5_wake_exit: assert property (@(posedge clk) disable iff (rst)
    ((modeQ == MODE_SILENT || modeQ == MODE_SLEEP) && anyWake) |=> (modeQ == MODE_FAILSAFE));

  a_r9_sleep_hold: assert property (@(posedge clk) disable iff (rst)
    (modeQ == MODE_SLEEP && !anyWake) |=> (modeQ == MODE_SLEEP));
endmodule

// File: rtl/lin_mode_dp.sv
module lin_mode_dp
  import linmode_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  ctrl_strobe_t strobe,
  input  lin_mode_e    curMode,
  input  logic         uvFlag,
  output logic         regEn,
  output logic         txEn,
  output logic         rxEn,
  output logic         txdDriveLow,
  output wake_src_e    wakeSrc
);
  wake_src_e srcQ;
  wake_src_e srcNext;
  logic      localSrc;

  always_comb begin
    if (strobe.clearSrc)     srcNext = SRC_NONE;
    else if (strobe.loadSrc) srcNext = strobe.newSrc;
    else                     srcNext = srcQ;
  end

  assign localSrc = (srcNext == SRC_PIN) || (srcNext == SRC_IGN);

  always_ff @(posedge clk) begin
    if (rst) begin
      srcQ        <= SRC_NONE;
      regEn       <= 1'b1;
      txEn        <= 1'b0;
      rxEn        <= 1'b0;
      txdDriveLow <= 1'b0;
    end else begin
      srcQ        <= srcNext;
      regEn       <= (strobe.nextMode != MODE_SLEEP);
      txEn        <= (strobe.nextMode == MODE_NORMAL) && !uvFlag;
      rxEn        <= (strobe.nextMode == MODE_NORMAL);
      txdDriveLow <= (strobe.nextMode == MODE_FAILSAFE) && localSrc;
    end
  end

  assign wakeSrc = srcQ;

  a_r7_uv_blocks_tx: assert property (@(posedge clk) disable iff (rst)
    uvFlag |=> !txEn);

  a_r6_drive_in_failsafe: assert property (@(posedge clk) disable iff (rst)
    txdDriveLow |-> (curMode == MODE_FAILSAFE));

  a_r4_reg_off_sleep: assert property (@(posedge clk) disable iff (rst)
    (curMode == MODE_SLEEP) |-> !regEn);

  a_r2_src_clear_normal: assert property (@(posedge clk) disable iff (rst)
    (curMode == MODE_NORMAL) |-> (wakeSrc == SRC_NONE));
endmodule

// File: rtl/lin_mode_top.sv
module lin_mode_top
  import linmode_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enIn,
  input  logic       txdIn,
  input  logic       uvFlag,
  input  logic       busWake,
  input  logic       pinWake,
  input  logic       ignWake,
  output logic [1:0] modeOut,
  output logic       regEn,
  output logic       txEn,
  output logic       rxEn,
  output logic       txdDriveLow,
  output logic [1:0] wakeSrc
);
  ctrl_strobe_t strobe;
  lin_mode_e    curMode;
  wake_src_e    srcOut;

  lin_mode_ctrl uCtrl (
    .clk(clk), .rst(rst), .enIn(enIn), .txdIn(txdIn),
    .busWake(busWake), .pinWake(pinWake), .ignWake(ignWake),
    .strobe(strobe), .curMode(curMode)
  );

  lin_mode_dp uDp (
    .clk(clk), .rst(rst), .strobe(strobe), .curMode(curMode), .uvFlag(uvFlag),
    .regEn(regEn), .txEn(txEn), .rxEn(rxEn), .txdDriveLow(txdDriveLow),
    .wakeSrc(srcOut)
  );

  assign modeOut = curMode;
  assign wakeSrc = srcOut;
endmodule

// File: tb/tb_lin_mode_top.sv
module tb_lin_mode_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enIn = 1'b0, txdIn = 1'b1, uvFlag = 1'b0;
  logic busWake = 1'b0, pinWake = 1'b0, ignWake = 1'b0;
  logic [1:0] modeOut, wakeSrc;
  logic regEn, txEn, rxEn, txdDriveLow;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  int mMode = 0, mSrc = 0;
  bit mEnPrev = 0;
  bit mReg = 1, mTx = 0, mRx = 0, mDrv = 0;

  always #10 clk = ~clk;

  lin_mode_top dut (
    .clk(clk), .rst(rst), .enIn(enIn), .txdIn(txdIn), .uvFlag(uvFlag),
    .busWake(busWake), .pinWake(pinWake), .ignWake(ignWake),
    .modeOut(modeOut), .regEn(regEn), .txEn(txEn), .rxEn(rxEn),
    .txdDriveLow(txdDriveLow), .wakeSrc(wakeSrc)
  );

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual cycles=%0d expected <=5000", cycles);
        finish_run();
      end
    end
  end

  task automatic model_update(bit r, bit en, bit txd, bit uv, bit bw, bit pw, bit iw);
    bit anyW;
    int ns;
    if (r) begin
      mMode = 0; mSrc = 0; mEnPrev = 0;
      mReg = 1; mTx = 0; mRx = 0; mDrv = 0;
      return;
    end
    anyW = bw | pw | iw;
    ns = pw ? 2 : (iw ? 3 : (bw ? 1 : 0));
    case (mMode)
      0: if (en && !mEnPrev) begin mMode = 1; mSrc = 0; end
      1: if (!en) mMode = txd ? 2 : 3;
      default: if (anyW) begin mMode = 0; mSrc = ns; end
    endcase
    mEnPrev = en;
    mReg = (mMode != 3);
    mTx  = (mMode == 1) && !uv;
    mRx  = (mMode == 1);
    mDrv = (mMode == 0) && (mSrc >= 2);
  endtask

  task automatic step(bit r, bit en, bit txd, bit uv, bit bw, bit pw, bit iw, string tag);
    rst = r; enIn = en; txdIn = txd; uvFlag = uv;
    busWake = bw; pinWake = pw; ignWake = iw;
    @(posedge clk);
    model_update(r, en, txd, uv, bw, pw, iw);
    @(negedge clk);
    checks++;
    if (modeOut !== 2'(mMode) || wakeSrc !== 2'(mSrc) || regEn !== mReg ||
        txEn !== mTx || rxEn !== mRx || txdDriveLow !== mDrv) begin
      fails++;
      $display("FAIL %s: actual mode=%0d src=%0d reg=%0b tx=%0b rx=%0b drv=%0b expected mode=%0d src=%0d reg=%0b tx=%0b rx=%0b drv=%0b",
               tag, modeOut, wakeSrc, regEn, txEn, rxEn, txdDriveLow,
               mMode, mSrc, mReg, mTx, mRx, mDrv);
    end
  endtask

  initial begin
    @(negedge clk);
    //    rst en txd uv bw pw iw
    step(1, 0, 1, 0, 0, 0, 0, "R1");
    step(1, 1, 1, 0, 0, 0, 0, "R1");
    step(0, 0, 1, 0, 0, 0, 0, "R1");
    step(0, 1, 1, 0, 0, 0, 0, "R2");   // rising enable -> normal
    step(0, 1, 1, 0, 0, 1, 1, "R8");   // wake in normal ignored
    step(0, 1, 1, 1, 0, 0, 0, "R7");   // undervoltage
    step(0, 1, 1, 1, 0, 0, 0, "R7");
    step(0, 1, 1, 0, 0, 0, 0, "R7");
    step(0, 0, 1, 0, 0, 0, 0, "R3");   // silent
    step(0, 0, 1, 1, 0, 0, 0, "R3");
    step(0, 1, 1, 0, 0, 0, 0, "R9");   // enable rise, no wake
    step(0, 1, 1, 0, 1, 0, 0, "R5");   // bus wake -> fail-safe, src bus
    step(0, 1, 1, 0, 0, 0, 0, "R6");   // no drive for bus source
    step(0, 0, 1, 0, 0, 0, 0, "R2");
    step(0, 1, 1, 0, 0, 0, 0, "R2");   // normal, src cleared
    step(0, 0, 0, 0, 0, 0, 0, "R4");   // sleep
    step(0, 0, 0, 0, 0, 0, 0, "R9");
    step(0, 1, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 1, 0, 1, 1, 1, "R5");   // priority: pin wins
    step(0, 0, 1, 0, 0, 0, 0, "R6");   // drive low held
    step(0, 0, 1, 0, 1, 0, 1, "R8");   // wake in fail-safe ignored
    step(0, 1, 1, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 1, 0, 1, "R5");   // ignition over bus
    step(0, 0, 0, 0, 0, 0, 0, "R6");
    step(0, 1, 1, 0, 0, 0, 0, "R2");
    step(0, 0, 1, 0, 0, 0, 0, "R3");
    step(0, 0, 1, 0, 1, 0, 0, "R5");   // bus only
    step(1, 1, 1, 0, 0, 0, 0, "R1");   // mid-run reset
    step(0, 1, 1, 0, 0, 0, 0, "R2");
    finish_run();
  end
endmodule